// File: doc/BRIEF.md
# Multi-Drive Head Positioning Sequencer

This block moves the read/write heads of up to four floppy drives. A positioning command names a drive, chooses between a seek to a target cylinder and a recalibrate to cylinder 0, and carries a 4-bit step-rate code. Each drive has its own engine. The engine issues step pulses on that drive's step line, sets its direction line, and keeps a present-cylinder number for the drive. When the operation finishes, the engine latches one completion event. The event carries seek-end, equipment-check and not-ready flags and is read and cleared by the interrupt/status logic next to this block.

The command port is occupied only for the single cycle in which a command is accepted. Once a drive starts stepping, commands for the other drives are still accepted, so all four drives can be positioning at the same time. Recalibrate gives up after a fixed number of pulses if the drive never reports track zero. A drive that drops its ready line ends its operation at once.

Top module: `head_pos_seq`

## Requirements
- R1: A command is accepted (`cmd_ack` high in that cycle) only when the addressed drive is idle and has no pending event. A command that is not accepted has no effect on any drive.
- R2: While one or more drives are stepping, a command addressed to an idle drive with no pending event is accepted and runs alongside the others.
- R3: Recalibrate clears the drive's present cylinder to 0 and sets its direction line to 1 when it is accepted. It then keeps pulsing while track zero is low. Once track zero is seen high, it ends with a seek-end event and no equipment-check.
- R4: If track zero is still low after RECAL_LIMIT (77) pulses, recalibrate ends with seek-end and equipment-check both set. An event never has equipment-check without seek-end.
- R5: Seek compares the target with the present cylinder before each pulse. The direction line is 0 when stepping toward higher cylinders and 1 when stepping toward cylinder 0. The present cylinder moves by one in the cycle each pulse begins. When the two are equal, the seek ends with seek-end, so a seek to the current cylinder issues no pulse.
- R6: If the drive's ready line is low in any cycle of an active operation, including the first cycle after acceptance, the operation ends in the next cycle. No further pulse is issued, and the event carries not-ready and seek-end.
- R7: Consecutive step-pulse rising edges of one operation are (16 − code) × UNIT_CYC clock cycles apart, where code F is the shortest interval. Each pulse is high for PULSE_W cycles.
- R8: An event stays latched until `evt_clear` for that drive is pulsed. Clearing an event removes all of its flags.
- R9: After reset, every drive is idle, and all step, direction, present-cylinder and event outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A positioning command is offered |
| cmd_drive | input | SEL_W | Addressed drive |
| cmd_recal | input | 1 | 1 = recalibrate, 0 = seek |
| cmd_cyl | input | CYL_W | Seek target cylinder |
| step_rate | input | 4 | Step-rate code, latched when the command is accepted |
| cmd_ack | output | 1 | The command is accepted this cycle |
| drv_ready | input | NUM_DRIVES | Per-drive ready |
| drv_trk0 | input | NUM_DRIVES | Per-drive track-zero |
| step_out | output | NUM_DRIVES | Per-drive step pulse |
| dir_out | output | NUM_DRIVES | Per-drive direction (1 = toward cylinder 0) |
| pcn_flat | output | NUM_DRIVES*CYL_W | Present cylinders; drive d sits at bits d*CYL_W upward |
| busy | output | NUM_DRIVES | Drive operation in progress |
| evt_valid | output | NUM_DRIVES | Completion event pending |
| evt_se | output | NUM_DRIVES | Seek-end flag of the event |
| evt_ec | output | NUM_DRIVES | Equipment-check flag of the event |
| evt_nr | output | NUM_DRIVES | Not-ready flag of the event |
| evt_clear | input | NUM_DRIVES | Clears the drive's pending event |

## Verification
The bench targets the recalibrate limit by holding track zero low for the whole run. An off-by-one limit shows up as 76 or 78 pulses, and a missing equipment-check flag shows up as a plain seek-end event. It overlaps three drives and sends a command to a drive that is already busy. A shared or wrongly decoded engine would then stop a running drive or retarget it, which changes its pulse count and final cylinder. Ready is dropped both before the first pulse and partway through a seek; a design that finishes the pulse train or misses the first cycle gives the wrong pulse count or no not-ready flag. Pulse spacing is measured at two rate codes, and a seek to the current cylinder is issued to catch a spurious step.

// File: rtl/hps_pkg.sv
package hps_pkg;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_EVAL = 2'd1,
    PS_STEP = 2'd2
  } pos_state_e;

  typedef struct packed {
    logic valid;
    logic se;
    logic ec;
    logic nr;
  } pos_evt_t;

endpackage

// File: rtl/hps_rate.sv
// Step interval in clock cycles from the 4-bit rate code: F is one unit, 0 is sixteen.
module hps_rate #(
  parameter int UNIT_CYC = 8000,
  parameter int EL_W     = 17
) (
  input  logic [3:0]      code,
  output logic [EL_W-1:0] interval
);
  logic [4:0] units;

  assign units    = 5'd16 - {1'b0, code};
  assign interval = EL_W'(units) * EL_W'(UNIT_CYC);
endmodule

// File: rtl/hps_drive.sv
// Positioning engine for one drive: evaluates before every pulse, then times the interval.
module hps_drive
  import hps_pkg::*;
#(
  parameter int CYL_W       = 8,
  parameter int UNIT_CYC    = 8000,
  parameter int PULSE_W     = 16,
  parameter int RECAL_LIMIT = 77
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_recal,
  input  logic [CYL_W-1:0] start_cyl,
  input  logic [3:0]       start_rate,
  input  logic             ready,
  input  logic             trk0,
  input  logic             evt_clr,
  output logic             busy,
  output logic             step,
  output logic             dir,
  output logic [CYL_W-1:0] pcn,
  output pos_evt_t         evt
);
  localparam int EL_W  = $clog2(16 * UNIT_CYC + 1);
  localparam int CNT_W = $clog2(RECAL_LIMIT + 1);

  pos_state_e       st_q, st_d;
  logic [CYL_W-1:0] pcn_q, pcn_d, tgt_q, tgt_d;
  logic             recal_q, recal_d, dir_q, dir_d;
  logic [3:0]       rate_q, rate_d;
  logic [EL_W-1:0]  el_q, el_d, interval;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  pos_evt_t         evt_q, evt_d;

  hps_rate #(.UNIT_CYC(UNIT_CYC), .EL_W(EL_W)) u_rate (
    .code     (rate_q),
    .interval (interval)
  );

  always_comb begin
    st_d    = st_q;
    pcn_d   = pcn_q;
    tgt_d   = tgt_q;
    recal_d = recal_q;
    dir_d   = dir_q;
    rate_d  = rate_q;
    el_d    = el_q;
    cnt_d   = cnt_q;
    evt_d   = evt_q;
    if (evt_q.valid && evt_clr) begin
      evt_d = '0;
    end
    unique case (st_q)
      PS_IDLE: begin
        if (start) begin
          st_d    = PS_EVAL;
          recal_d = start_recal;
          tgt_d   = start_cyl;
          rate_d  = start_rate;
          cnt_d   = '0;
          if (start_recal) begin
            pcn_d = '0;
            dir_d = 1'b1;
          end
        end
      end
      PS_EVAL: begin
        if (!ready) begin
          st_d  = PS_IDLE;
          evt_d = '{valid: 1'b1, se: 1'b1, ec: 1'b0, nr: 1'b1};
        end else if (recal_q && trk0) begin
          st_d  = PS_IDLE;
          evt_d = '{valid: 1'b1, se: 1'b1, ec: 1'b0, nr: 1'b0};
        end else if (recal_q && (cnt_q == CNT_W'(RECAL_LIMIT))) begin
          st_d  = PS_IDLE;
          evt_d = '{valid: 1'b1, se: 1'b1, ec: 1'b1, nr: 1'b0};
        end else if (!recal_q && (pcn_q == tgt_q)) begin
          st_d  = PS_IDLE;
          evt_d = '{valid: 1'b1, se: 1'b1, ec: 1'b0, nr: 1'b0};
        end else begin
          st_d  = PS_STEP;
          el_d  = '0;
          cnt_d = cnt_q + CNT_W'(1);
          if (!recal_q) begin
            dir_d = (tgt_q < pcn_q);
            pcn_d = (tgt_q < pcn_q) ? pcn_q - CYL_W'(1) : pcn_q + CYL_W'(1);
          end
        end
      end
      PS_STEP: begin
        if (!ready) begin
          st_d  = PS_IDLE;
          evt_d = '{valid: 1'b1, se: 1'b1, ec: 1'b0, nr: 1'b1};
        end else if (el_q == interval - EL_W'(2)) begin
          st_d = PS_EVAL;
        end else begin
          el_d = el_q + EL_W'(1);
        end
      end
      default: st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PS_IDLE;
      pcn_q   <= '0;
      tgt_q   <= '0;
      recal_q <= 1'b0;
      dir_q   <= 1'b0;
      rate_q  <= '0;
      el_q    <= '0;
      cnt_q   <= '0;
      evt_q   <= '0;
    end else begin
      st_q    <= st_d;
      pcn_q   <= pcn_d;
      tgt_q   <= tgt_d;
      recal_q <= recal_d;
      dir_q   <= dir_d;
      rate_q  <= rate_d;
      el_q    <= el_d;
      cnt_q   <= cnt_d;
      evt_q   <= evt_d;
    end
  end

  assign busy = (st_q != PS_IDLE);
  assign step = (st_q == PS_STEP) && (el_q < EL_W'(PULSE_W));
  assign dir  = dir_q;
  assign pcn  = pcn_q;
  assign evt  = evt_q;
endmodule

// File: rtl/head_pos_seq.sv
// Top: reset release synchronizer, command decode, one engine per drive.
module head_pos_seq
  import hps_pkg::*;
#(
  parameter int  NUM_DRIVES  = 4,
  parameter int  CYL_W       = 8,
  parameter int  UNIT_CYC    = 8000,
  parameter int  PULSE_W     = 16,
  parameter int  RECAL_LIMIT = 77,
  localparam int SEL_W       = $clog2(NUM_DRIVES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  logic [SEL_W-1:0]            cmd_drive,
  input  logic                        cmd_recal,
  input  logic [CYL_W-1:0]            cmd_cyl,
  input  logic [3:0]                  step_rate,
  output logic                        cmd_ack,
  input  logic [NUM_DRIVES-1:0]       drv_ready,
  input  logic [NUM_DRIVES-1:0]       drv_trk0,
  output logic [NUM_DRIVES-1:0]       step_out,
  output logic [NUM_DRIVES-1:0]       dir_out,
  output logic [NUM_DRIVES*CYL_W-1:0] pcn_flat,
  output logic [NUM_DRIVES-1:0]       busy,
  output logic [NUM_DRIVES-1:0]       evt_valid,
  output logic [NUM_DRIVES-1:0]       evt_se,
  output logic [NUM_DRIVES-1:0]       evt_ec,
  output logic [NUM_DRIVES-1:0]       evt_nr,
  input  logic [NUM_DRIVES-1:0]       evt_clear
);
  logic                  rst_s1_q, rst_s2_q, rst_int_n;
  logic [NUM_DRIVES-1:0] start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  assign cmd_ack = cmd_valid && !busy[cmd_drive] && !evt_valid[cmd_drive];

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
    pos_evt_t evt;

    assign start[d] = cmd_ack && (cmd_drive == SEL_W'(d));

    hps_drive #(
      .CYL_W       (CYL_W),
      .UNIT_CYC    (UNIT_CYC),
      .PULSE_W     (PULSE_W),
      .RECAL_LIMIT (RECAL_LIMIT)
    ) u_drv (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .start       (start[d]),
      .start_recal (cmd_recal),
      .start_cyl   (cmd_cyl),
      .start_rate  (step_rate),
      .ready       (drv_ready[d]),
      .trk0        (drv_trk0[d]),
      .evt_clr     (evt_clear[d]),
      .busy        (busy[d]),
      .step        (step_out[d]),
      .dir         (dir_out[d]),
      .pcn         (pcn_flat[d*CYL_W +: CYL_W]),
      .evt         (evt)
    );

    assign evt_valid[d] = evt.valid;
    assign evt_se[d]    = evt.se;
    assign evt_ec[d]    = evt.ec;
    assign evt_nr[d]    = evt.nr;
  end
endmodule

// File: rtl/hps_checker.sv
module hps_checker #(
  parameter int  NUM_DRIVES = 4,
  parameter int  CYL_W      = 8,
  localparam int SEL_W      = $clog2(NUM_DRIVES)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cmd_valid,
  input logic [SEL_W-1:0]            cmd_drive,
  input logic                        cmd_ack,
  input logic [NUM_DRIVES-1:0]       drv_ready,
  input logic [NUM_DRIVES-1:0]       step_out,
  input logic [NUM_DRIVES*CYL_W-1:0] pcn_flat,
  input logic [NUM_DRIVES-1:0]       busy,
  input logic [NUM_DRIVES-1:0]       evt_valid,
  input logic [NUM_DRIVES-1:0]       evt_se,
  input logic [NUM_DRIVES-1:0]       evt_ec,
  input logic [NUM_DRIVES-1:0]       evt_nr,
  input logic [NUM_DRIVES-1:0]       evt_clear
);
  // R1: only an idle drive without a pending event takes a command, and it starts next cycle
  p_ack_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |-> (cmd_valid && !busy[cmd_drive] && !evt_valid[cmd_drive]));
  p_ack_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |=> busy[$past(cmd_drive)]);

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_chk
    // R7: a pulse belongs to an active operation
    p_step_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      step_out[d] |-> busy[d]);
    // R6: ready loss ends the operation with a not-ready event
    p_ready_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[d] && !drv_ready[d]) |=> (!busy[d] && evt_valid[d] && evt_nr[d] && evt_se[d]));
    // R4: equipment-check only comes with seek-end
    p_ec_with_se_r4: assert property (@(posedge clk) disable iff (!rst_n)
      evt_ec[d] |-> (evt_se[d] && evt_valid[d]));
    // R8: an event holds until cleared
    p_evt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid[d] && !evt_clear[d]) |=> evt_valid[d]);
    // R5: an idle drive that is not being started keeps its cylinder
    p_pcn_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy[d] && !(cmd_ack && (cmd_drive == SEL_W'(d))))
        |=> $stable(pcn_flat[d*CYL_W +: CYL_W]));
  end
endmodule

bind head_pos_seq hps_checker #(
  .NUM_DRIVES (NUM_DRIVES),
  .CYL_W      (CYL_W)
) u_hps_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_drive (cmd_drive),
  .cmd_ack   (cmd_ack),
  .drv_ready (drv_ready),
  .step_out  (step_out),
  .pcn_flat  (pcn_flat),
  .busy      (busy),
  .evt_valid (evt_valid),
  .evt_se    (evt_se),
  .evt_ec    (evt_ec),
  .evt_nr    (evt_nr),
  .evt_clear (evt_clear)
);

// File: tb/head_pos_seq_bench.sv
`timescale 1ns/1ps
module head_pos_seq_bench;
  localparam int N     = 4;
  localparam int CW    = 8;
  localparam int UNIT  = 4;
  localparam int PW    = 2;
  localparam int LIMIT = 77;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_drive = '0;
  logic          cmd_recal = 1'b0;
  logic [CW-1:0] cmd_cyl = '0;
  logic [3:0]    step_rate = 4'hF;
  logic          cmd_ack;
  logic [N-1:0]  drv_ready = '1;
  logic [N-1:0]  drv_trk0 = '0;
  logic [N-1:0]  step_out, dir_out, busy, evt_valid, evt_se, evt_ec, evt_nr;
  logic [N-1:0]  evt_clear = '0;
  logic [N*CW-1:0] pcn_flat;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  head_pos_seq #(.NUM_DRIVES(N), .CYL_W(CW), .UNIT_CYC(UNIT), .PULSE_W(PW),
                 .RECAL_LIMIT(LIMIT)) u_head_pos_seq (.*);

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // reference model: 0 idle, 1 evaluate, 2 stepping
  int m_st[N], m_el[N], m_cnt[N], m_pcn[N], m_tgt[N], m_rate[N];
  bit m_recal[N], m_dir[N], m_ev[N], m_se[N], m_ec[N], m_nr[N];

  function automatic bit m_ack(input int d);
    return cmd_valid && (int'(cmd_drive) == d) && (m_st[d] == 0) && !m_ev[d];
  endfunction

  task automatic m_end(input int d, input bit ec, input bit nr);
    m_st[d] = 0; m_ev[d] = 1; m_se[d] = 1; m_ec[d] = ec; m_nr[d] = nr;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < N; d++) begin
        m_st[d] = 0; m_el[d] = 0; m_cnt[d] = 0; m_pcn[d] = 0; m_tgt[d] = 0;
        m_rate[d] = 0; m_recal[d] = 0; m_dir[d] = 0; m_ev[d] = 0;
        m_se[d] = 0; m_ec[d] = 0; m_nr[d] = 0;
      end
    end else begin
      cyc++;
      for (int d = 0; d < N; d++) begin
        bit ack;
        ack = m_ack(d);
        if (m_ev[d] && evt_clear[d]) begin
          m_ev[d] = 0; m_se[d] = 0; m_ec[d] = 0; m_nr[d] = 0;
        end
        case (m_st[d])
          0: if (ack) begin
            m_st[d] = 1; m_recal[d] = cmd_recal; m_tgt[d] = int'(cmd_cyl);
            m_rate[d] = int'(step_rate); m_cnt[d] = 0;
            if (cmd_recal) begin m_pcn[d] = 0; m_dir[d] = 1; end
          end
          1: begin
            if (!drv_ready[d]) m_end(d, 0, 1);
            else if (m_recal[d] && drv_trk0[d]) m_end(d, 0, 0);
            else if (m_recal[d] && m_cnt[d] == LIMIT) m_end(d, 1, 0);
            else if (!m_recal[d] && m_pcn[d] == m_tgt[d]) m_end(d, 0, 0);
            else begin
              m_st[d] = 2; m_el[d] = 0; m_cnt[d]++;
              if (!m_recal[d]) begin
                m_dir[d] = (m_tgt[d] < m_pcn[d]);
                m_pcn[d] += m_dir[d] ? -1 : 1;
              end
            end
          end
          default: begin
            if (!drv_ready[d]) m_end(d, 0, 1);
            else if (m_el[d] == (16 - m_rate[d]) * UNIT - 2) m_st[d] = 1;
            else m_el[d]++;
          end
        endcase
      end
    end
  end

  // per-cycle comparison plus pulse monitor
  int rises[N], period[N], last_rise[N];
  logic [N-1:0] step_prev = '0;

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      bit eack;
      eack = 0;
      for (int d = 0; d < N; d++) if (m_ack(d)) eack = 1;
      check("R1", "cmd_ack", int'(cmd_ack), int'(eack));
      for (int d = 0; d < N; d++) begin
        check("R7", $sformatf("step[%0d]", d), int'(step_out[d]),
              int'(m_st[d] == 2 && m_el[d] < PW));
        check("R5", $sformatf("dir[%0d]", d), int'(dir_out[d]), int'(m_dir[d]));
        check("R5", $sformatf("pcn[%0d]", d), int'(pcn_flat[d*CW +: CW]), m_pcn[d]);
        check("R6", $sformatf("busy[%0d]", d), int'(busy[d]), int'(m_st[d] != 0));
        check("R8", $sformatf("evt[%0d]", d),
              int'({evt_valid[d], evt_se[d], evt_ec[d], evt_nr[d]}),
              int'({m_ev[d], m_se[d], m_ec[d], m_nr[d]}));
        if (step_out[d] && !step_prev[d]) begin
          rises[d]++;
          period[d] = cyc - last_rise[d];
          last_rise[d] = cyc;
        end
      end
      step_prev = step_out;
    end
  end

  task automatic issue(input int d, input bit recal, input int cyl, input int rate);
    @(negedge clk);
    cmd_valid = 1; cmd_drive = 2'(d); cmd_recal = recal;
    cmd_cyl = CW'(cyl); step_rate = 4'(rate);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic clear_evt(input logic [N-1:0] m);
    @(negedge clk); evt_clear = m;
    @(negedge clk); evt_clear = '0;
  endtask

  task automatic wait_idle(input logic [N-1:0] m);
    while ((busy & m) != 0) @(negedge clk);
    @(negedge clk); #3;
  endtask

  task automatic zero_counts();
    for (int d = 0; d < N; d++) rises[d] = 0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run hung got busy expected finished");
    finish_run();
  end

  initial begin
    for (int d = 0; d < N; d++) begin rises[d] = 0; period[d] = 0; last_rise[d] = 0; end
    repeat (3) @(negedge clk);
    #3;
    // R9 reset state
    check("R9", "busy", int'(busy), 0);
    check("R9", "step", int'(step_out), 0);
    check("R9", "dir", int'(dir_out), 0);
    check("R9", "pcn", int'(pcn_flat), 0);
    check("R9", "evt_valid", int'(evt_valid), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R5 seek upward with the shortest interval
    zero_counts();
    issue(0, 0, 10, 15);
    wait_idle(4'b0001);
    check("R5", "seek up pulses", rises[0], 10);
    check("R5", "seek up pcn", int'(pcn_flat[7:0]), 10);
    check("R7", "period code F", period[0], 16 - 15 ? UNIT : 0);
    check("R5", "seek-end only", int'({evt_se[0], evt_ec[0], evt_nr[0]}), 3'b100);
    clear_evt(4'b0001);
    check("R8", "cleared", int'(evt_valid[0]), 0);

    // R3 recalibrate reaching track zero after five pulses
    issue(1, 0, 6, 15);
    wait_idle(4'b0010);
    clear_evt(4'b0010);
    zero_counts();
    issue(1, 1, 0, 15);
    check("R3", "dir high", int'(dir_out[1]), 1);
    check("R3", "pcn cleared", int'(pcn_flat[15:8]), 0);
    while (rises[1] < 5) begin @(negedge clk); #3; end
    drv_trk0[1] = 1;
    wait_idle(4'b0010);
    drv_trk0[1] = 0;
    check("R3", "recal pulses", rises[1], 5);
    check("R3", "no equipment check", int'({evt_se[1], evt_ec[1]}), 2'b10);

    // R2 overlap three drives; R1 busy drive refuses a new target
    zero_counts();
    issue(2, 1, 0, 15);
    issue(3, 0, 3, 13);
    issue(0, 0, 4, 15);
    @(negedge clk); #3;
    check("R2", "three busy", int'(busy & 4'b1101), 4'b1101);
    issue(0, 0, 100, 15);
    wait_idle(4'b1101);
    check("R4", "recal limit pulses", rises[2], LIMIT);
    check("R4", "equipment check", int'({evt_se[2], evt_ec[2]}), 2'b11);
    check("R2", "drive3 pcn", int'(pcn_flat[31:24]), 3);
    check("R7", "period code D", period[3], 3 * UNIT);
    check("R1", "drive0 pcn kept target", int'(pcn_flat[7:0]), 4);
    check("R5", "seek down pulses", rises[0], 6);
    check("R5", "dir low toward 0 ends high", int'(dir_out[0]), 1);

    // R1 pending event blocks a command
    issue(2, 0, 40, 15);
    repeat (3) @(negedge clk);
    #3;
    check("R1", "pending refuses", int'(busy[2]), 0);
    check("R1", "event untouched", int'(evt_ec[2]), 1);
    clear_evt(4'b1111);

    // R6 not ready at start, then ready lost after three pulses
    zero_counts();
    drv_ready[1] = 0;
    issue(1, 0, 20, 15);
    wait_idle(4'b0010);
    check("R6", "no pulse", rises[1], 0);
    check("R6", "nr flag", int'({evt_se[1], evt_nr[1]}), 2'b11);
    drv_ready[1] = 1;
    clear_evt(4'b0010);
    issue(1, 0, 50, 15);
    while (rises[1] < 3) begin @(negedge clk); #3; end
    drv_ready[1] = 0;
    wait_idle(4'b0010);
    drv_ready[1] = 1;
    check("R6", "pulses before abort", rises[1], 3);
    check("R6", "pcn after abort", int'(pcn_flat[15:8]), 3);
    check("R6", "nr after abort", int'(evt_nr[1]), 1);
    clear_evt(4'b0010);

    // R5 seek to the present cylinder
    zero_counts();
    issue(3, 0, 3, 0);
    wait_idle(4'b1000);
    check("R5", "zero-length seek", rises[3], 0);
    check("R5", "zero-length seek-end", int'(evt_se[3]), 1);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule